// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Unit

This block sits beside a memory controller's ECC checker and keeps a record of the first error of each class until software has dealt with it. It keeps two independent capture sets, one for correctable errors and one for uncorrectable errors. A capture set holds the 34-bit error address, the 64-bit data word, the 8-bit syndrome and the 14-bit ID of the requester that made the access.

Each class has two status bits. One says that a record is held. The other says that a further error of the same class arrived while the record was frozen, so that event was lost. The interrupt line is the OR of the status bits that are not masked, and a global mask bit can silence it. Software reads the records through a flat 32-bit register window with a 4-byte stride. It clears status with write-one-to-clear, and it reads a service register that always names the correctable class first when both classes are pending.

Error detection and the bus fabric are outside this block. The checker delivers a one-cycle valid pulse with the error fields. Register reads are combinational, and a write takes effect at the clock edge on which `reg_we` is high.

Top module: `ecc_fault_recorder`

## Requirements
- R1: After reset all status bits are 0, every capture register and the source-ID register read 0, the mask register reads 0x8000_0000 (globally masked) and `irq` is 0.
- R2: A `ce_valid` pulse while status bit 0 is clear latches the correctable record, which is readable from the next cycle. Offset 0x10 holds address bits [31:0], 0x14 holds address bits [33:32] in its bits [1:0], 0x18 holds data bits [31:0], 0x1C holds data bits [63:32] and 0x20 holds the syndrome in bits [15:8]. The same pulse sets status bit 0 (status register at offset 0x00).
- R3: A `ue_valid` pulse while status bit 2 is clear latches the uncorrectable record at offsets 0x30, 0x34, 0x38, 0x3C and 0x40, with the same field layout as R2, and sets status bit 2.
- R4: The source-ID register at offset 0x50 returns the captured correctable requester ID in bits [29:16] and the captured uncorrectable requester ID in bits [13:0]. All other bits read 0.
- R5: While a class's held bit (bit 0 for correctable, bit 2 for uncorrectable) is set, further events of that class leave the record unchanged and set that class's overrun bit (bit 1 or bit 3).
- R6: Writing to the acknowledge register at offset 0x04 clears exactly the status bits written as 1, using the same bit positions as the status register. Bits written as 0 are kept, and the register reads 0. After bit 0 or bit 2 is cleared, the next event of that class is captured again.
- R7: The mask register at offset 0x08 is read/write in bit 31 (global mask) and in bits [3:0] (one mask per status bit). Its other bits read 0. `irq` is 1 exactly when bit 31 is 0 and some status bit is set whose mask bit is 0.
- R8: The service register at offset 0x0C reads 1 when either correctable status bit is set. Otherwise it reads 2 when either uncorrectable status bit is set, and 0 when no status bit is set.
- R9: Writes to the status, service, capture and source-ID offsets, and to unmapped offsets, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_valid | input | 1 | Correctable error event pulse |
| ce_addr | input | 34 | Correctable error address |
| ce_data | input | 64 | Correctable error data word |
| ce_synd | input | 8 | Correctable error syndrome |
| ce_src | input | 14 | Correctable error requester ID |
| ue_valid | input | 1 | Uncorrectable error event pulse |
| ue_addr | input | 34 | Uncorrectable error address |
| ue_data | input | 64 | Uncorrectable error data word |
| ue_synd | input | 8 | Uncorrectable error syndrome |
| ue_src | input | 14 | Uncorrectable error requester ID |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences cover four cases: a first event into an empty class, a repeat event into a frozen class, both classes pending together for the priority check, and masking by single bits and by the global bit. The repeat event separates a design that freezes its record from one that overwrites it. The pending-together case separates correct priority from reversed priority. A random phase then mixes events of both classes with random acknowledge patterns, random mask values and writes to read-only offsets. After every step each register and `irq` are compared with a model kept in the bench. Partial acknowledge patterns expose a wrong bit-to-class mapping, and random fields with all-ones high bits expose truncated address or syndrome placement.

// File: rtl/ecc_cap_pkg.sv
// Package: register offsets and service codes shared by the capture unit.
// Assumes byte offsets with a 4-byte stride on a 32-bit register window.
package ecc_cap_pkg;
    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFF_STATUS  = 8'h00;
    localparam logic [REG_AW-1:0] OFF_ACK     = 8'h04;
    localparam logic [REG_AW-1:0] OFF_MASK    = 8'h08;
    localparam logic [REG_AW-1:0] OFF_SERVICE = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_CE_BASE = 8'h10;
    localparam logic [REG_AW-1:0] OFF_UE_BASE = 8'h30;
    localparam logic [REG_AW-1:0] OFF_SRC     = 8'h50;

    // word index inside a capture set
    localparam logic [REG_AW-1:0] SUB_ADDR_LO = 8'h00;
    localparam logic [REG_AW-1:0] SUB_ADDR_HI = 8'h04;
    localparam logic [REG_AW-1:0] SUB_DATA_LO = 8'h08;
    localparam logic [REG_AW-1:0] SUB_DATA_HI = 8'h0C;
    localparam logic [REG_AW-1:0] SUB_SYND    = 8'h10;

    localparam int SYND_LSB    = 8;
    localparam int SRC_CE_LSB  = 16;
    localparam int GLOBAL_MASK = 31;

    typedef enum logic [1:0] {
        SVC_NONE = 2'd0,
        SVC_CE   = 2'd1,
        SVC_UE   = 2'd2
    } svc_e;
endpackage

// File: rtl/ecc_cap_slot.sv
// Module: one capture set (address, data, syndrome, requester ID) plus its
// held and overrun flags. Assumes ev_valid is a single-cycle pulse per error.
module ecc_cap_slot #(
    parameter int AW = 34,
    parameter int DW = 64,
    parameter int SW = 8,
    parameter int IW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    input  logic [AW-1:0] ev_addr,
    input  logic [DW-1:0] ev_data,
    input  logic [SW-1:0] ev_synd,
    input  logic [IW-1:0] ev_src,
    input  logic          clr_held,
    input  logic          clr_ovr,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_data,
    output logic [SW-1:0] cap_synd,
    output logic [IW-1:0] cap_src,
    output logic          held,
    output logic          overrun
);
    // Latch the record only when no record is currently held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
            cap_synd <= '0;
            cap_src  <= '0;
        end else if (ev_valid && !held) begin
            cap_addr <= ev_addr;
            cap_data <= ev_data;
            cap_synd <= ev_synd;
            cap_src  <= ev_src;
        end
    end

    // Held flag: set by a fresh capture, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) held <= 1'b0;
        else        held <= (held && !clr_held) || (ev_valid && !held);
    end

    // Overrun flag: set by an event that found the record frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= (overrun && !clr_ovr) || (ev_valid && held);
    end
endmodule

// File: rtl/ecc_cap_irq.sv
// Module: mask register and interrupt combine. Assumes status bits are
// registered elsewhere; irq follows them combinationally.
module ecc_cap_irq #(
    parameter int NST = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mask_we,
    input  logic [31:0]    mask_wdata,
    input  logic [NST-1:0] status,
    output logic [31:0]    mask_q,
    output logic           irq
);
    import ecc_cap_pkg::*;

    localparam logic [31:0] WR_BITS = (32'd1 << GLOBAL_MASK) | ((32'd1 << NST) - 32'd1);
    localparam logic [31:0] RST_VAL = 32'd1 << GLOBAL_MASK;

    // Hold the writable mask bits; reset comes up globally masked.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= RST_VAL;
        else if (mask_we) mask_q <= mask_wdata & WR_BITS;
    end

    // Raise irq for any unmasked status bit unless globally masked.
    always_comb begin
        irq = !mask_q[GLOBAL_MASK] && (|(status & ~mask_q[NST-1:0]));
    end
endmodule

// File: rtl/ecc_cap_arb.sv
// Module: picks the class software should service next. Lower class index
// wins; class 0 is correctable. Assumes two status bits per class.
module ecc_cap_arb #(
    parameter int NCLS = 2
) (
    input  logic [2*NCLS-1:0] status,
    output logic [1:0]        svc
);
    // Scan from highest to lowest index so the lowest pending class wins.
    always_comb begin
        svc = 2'd0;
        for (int g = NCLS - 1; g >= 0; g--) begin
            if (status[2*g] || status[2*g+1]) svc = 2'(g + 1);
        end
    end
endmodule

// File: rtl/ecc_fault_recorder.sv
// Module: top of the ECC error capture unit. Two capture sets (correctable,
// uncorrectable), W1C status, mask, service code and a 32-bit register window.
// Assumes reads are combinational and writes take effect at the clock edge.
module ecc_fault_recorder #(
    parameter int AW = 34,
    parameter int DW = 64,
    parameter int SW = 8,
    parameter int IW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_valid,
    input  logic [AW-1:0] ce_addr,
    input  logic [DW-1:0] ce_data,
    input  logic [SW-1:0] ce_synd,
    input  logic [IW-1:0] ce_src,
    input  logic          ue_valid,
    input  logic [AW-1:0] ue_addr,
    input  logic [DW-1:0] ue_data,
    input  logic [SW-1:0] ue_synd,
    input  logic [IW-1:0] ue_src,
    input  logic [7:0]    reg_addr,
    input  logic          reg_we,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq
);
    import ecc_cap_pkg::*;

    localparam int NCLS = 2;
    localparam int NST  = 2 * NCLS;

    logic [AW-1:0]   cap_addr [NCLS];
    logic [DW-1:0]   cap_data [NCLS];
    logic [SW-1:0]   cap_synd [NCLS];
    logic [IW-1:0]   cap_src  [NCLS];
    logic [NCLS-1:0] held;
    logic [NCLS-1:0] ovr;
    logic [NST-1:0]  status_w;
    logic [NST-1:0]  ack_clr;
    logic [31:0]     mask_q;
    logic [1:0]      svc_code;
    logic            ack_we;
    logic            mask_we;

    // Decode write strobes for the two writable registers.
    always_comb begin
        ack_we  = reg_we && (reg_addr == OFF_ACK);
        mask_we = reg_we && (reg_addr == OFF_MASK);
        ack_clr = ack_we ? reg_wdata[NST-1:0] : '0;
    end

    for (genvar g = 0; g < NCLS; g++) begin : g_slot
        ecc_cap_slot #(.AW(AW), .DW(DW), .SW(SW), .IW(IW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_valid (g == 0 ? ce_valid : ue_valid),
            .ev_addr  (g == 0 ? ce_addr  : ue_addr),
            .ev_data  (g == 0 ? ce_data  : ue_data),
            .ev_synd  (g == 0 ? ce_synd  : ue_synd),
            .ev_src   (g == 0 ? ce_src   : ue_src),
            .clr_held (ack_clr[2*g]),
            .clr_ovr  (ack_clr[2*g+1]),
            .cap_addr (cap_addr[g]),
            .cap_data (cap_data[g]),
            .cap_synd (cap_synd[g]),
            .cap_src  (cap_src[g]),
            .held     (held[g]),
            .overrun  (ovr[g])
        );
        assign status_w[2*g]   = held[g];
        assign status_w[2*g+1] = ovr[g];
    end

    ecc_cap_irq #(.NST(NST)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (reg_wdata),
        .status     (status_w),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    ecc_cap_arb #(.NCLS(NCLS)) u_arb (
        .status (status_w),
        .svc    (svc_code)
    );

    // Select one capture word of class g by sub-offset.
    function automatic logic [31:0] cap_word(input int g, input logic [7:0] sub);
        logic [31:0] w;
        case (sub)
            SUB_ADDR_LO: w = cap_addr[g][31:0];
            SUB_ADDR_HI: w = 32'(cap_addr[g][AW-1:32]);
            SUB_DATA_LO: w = cap_data[g][31:0];
            SUB_DATA_HI: w = cap_data[g][63:32];
            SUB_SYND:    w = 32'(cap_synd[g]) << SYND_LSB;
            default:     w = '0;
        endcase
        return w;
    endfunction

    // Read mux over the register window; unmapped offsets read 0.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_STATUS)
            reg_rdata = 32'(status_w);
        else if (reg_addr == OFF_MASK)
            reg_rdata = mask_q;
        else if (reg_addr == OFF_SERVICE)
            reg_rdata = 32'(svc_code);
        else if (reg_addr == OFF_SRC)
            reg_rdata = (32'(cap_src[0]) << SRC_CE_LSB) | 32'(cap_src[1]);
        else if (reg_addr >= OFF_CE_BASE && reg_addr <= OFF_CE_BASE + SUB_SYND)
            reg_rdata = cap_word(0, reg_addr - OFF_CE_BASE);
        else if (reg_addr >= OFF_UE_BASE && reg_addr <= OFF_UE_BASE + SUB_SYND)
            reg_rdata = cap_word(1, reg_addr - OFF_UE_BASE);
    end
endmodule

// File: rtl/ecc_cap_checker.sv
// Checker: temporal properties of the capture unit, bound to the top.
module ecc_cap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_valid,
    input logic        ue_valid,
    input logic [3:0]  status_w,
    input logic [3:0]  ack_clr,
    input logic [31:0] mask_q,
    input logic [1:0]  svc_code,
    input logic        irq,
    input logic [33:0] ce_rec_addr,
    input logic [33:0] ue_rec_addr
);
    assert_ce_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_valid && !status_w[0] |=> status_w[0]);

    assert_ue_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ue_valid && !status_w[2] |=> status_w[2]);

    assert_ce_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_w[0] && !ack_clr[0] |=> $stable(ce_rec_addr));

    assert_ue_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_w[2] && !ack_clr[2] |=> $stable(ue_rec_addr));

    assert_ce_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ce_valid && status_w[0] |=> status_w[1]);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_clr[0] && !ce_valid |=> !status_w[0]);

    assert_global_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[31] |-> !irq);

    assert_ce_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w[0] || status_w[1]) |-> svc_code == 2'd1);
endmodule

bind ecc_fault_recorder ecc_cap_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_valid    (ce_valid),
    .ue_valid    (ue_valid),
    .status_w    (status_w),
    .ack_clr     (ack_clr),
    .mask_q      (mask_q),
    .svc_code    (svc_code),
    .irq         (irq),
    .ce_rec_addr (cap_addr[0]),
    .ue_rec_addr (cap_addr[1])
);

// File: tb/tb_ecc_fault_recorder.sv
module tb_ecc_fault_recorder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_valid = 1'b0, ue_valid = 1'b0;
    logic [33:0] ce_addr = '0, ue_addr = '0;
    logic [63:0] ce_data = '0, ue_data = '0;
    logic [7:0]  ce_synd = '0, ue_synd = '0;
    logic [13:0] ce_src = '0, ue_src = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // model state
    logic [3:0]  m_st;
    logic [31:0] m_mask;
    logic [33:0] m_addr [2];
    logic [63:0] m_data [2];
    logic [7:0]  m_synd [2];
    logic [13:0] m_src  [2];

    always #4 clk = ~clk;

    ecc_fault_recorder dut (
        .clk(clk), .rst_n(rst_n),
        .ce_valid(ce_valid), .ce_addr(ce_addr), .ce_data(ce_data), .ce_synd(ce_synd), .ce_src(ce_src),
        .ue_valid(ue_valid), .ue_addr(ue_addr), .ue_data(ue_data), .ue_synd(ue_synd), .ue_src(ue_src),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic exp_irq();
        return !m_mask[31] && (|(m_st & ~m_mask[3:0]));
    endfunction

    function automatic logic [31:0] exp_svc();
        if (m_st[1:0] != 0) return 32'd1;
        if (m_st[3:2] != 0) return 32'd2;
        return 32'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
        if (a == 8'h04) m_st = m_st & ~d[3:0];
        if (a == 8'h08) m_mask = d & 32'h8000_000F;
    endtask

    task automatic fire(input int c, input logic [33:0] a, input logic [63:0] d,
                        input logic [7:0] s, input logic [13:0] id);
        if (c == 0) begin ce_valid = 1; ce_addr = a; ce_data = d; ce_synd = s; ce_src = id; end
        else        begin ue_valid = 1; ue_addr = a; ue_data = d; ue_synd = s; ue_src = id; end
        @(posedge clk); @(negedge clk);
        ce_valid = 0; ue_valid = 0;
        if (!m_st[2*c]) begin
            m_st[2*c] = 1'b1;
            m_addr[c] = a; m_data[c] = d; m_synd[c] = s; m_src[c] = id;
        end else begin
            m_st[2*c+1] = 1'b1;
        end
    endtask

    task automatic fire_rand(input int c);
        fire(c, {$urandom, $urandom} & 34'h3_FFFF_FFFF, {$urandom, $urandom},
             8'($urandom), 14'($urandom));
    endtask

    task automatic check_all();
        for (int c = 0; c < 2; c++) begin
            logic [7:0] b;
            string t;
            b = (c == 0) ? 8'h10 : 8'h30;
            t = (c == 0) ? "R2" : "R3";
            rd_chk(t, b + 8'h00, m_addr[c][31:0]);
            rd_chk(t, b + 8'h04, 32'(m_addr[c][33:32]));
            rd_chk(t, b + 8'h08, m_data[c][31:0]);
            rd_chk(t, b + 8'h0C, m_data[c][63:32]);
            rd_chk(t, b + 8'h10, 32'(m_synd[c]) << 8);
        end
        rd_chk("R4", 8'h50, (32'(m_src[0]) << 16) | 32'(m_src[1]));
        rd_chk("R6", 8'h00, 32'(m_st));
        rd_chk("R6", 8'h04, 32'd0);
        rd_chk("R7", 8'h08, m_mask);
        rd_chk("R8", 8'h0C, exp_svc());
        check("R7 irq", 32'(irq), 32'(exp_irq()));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_st = '0; m_mask = 32'h8000_0000;
        for (int c = 0; c < 2; c++) begin
            m_addr[c] = '0; m_data[c] = '0; m_synd[c] = '0; m_src[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_chk("R1 mask", 8'h08, 32'h8000_0000);
        rd_chk("R1 status", 8'h00, 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        check_all();

        // R2, R4, R7: first correctable event with all-ones high fields
        wr(8'h08, 32'h0);
        fire(0, 34'h3_DEAD_BEEF, 64'hFEDC_BA98_7654_3210, 8'hF4, 14'h3FFF);
        rd_chk("R2 addr_hi", 8'h14, 32'h3);
        rd_chk("R2 synd", 8'h20, 32'h0000_F400);
        rd_chk("R4 src", 8'h50, 32'h3FFF_0000);
        check("R7 irq on", 32'(irq), 32'd1);
        check_all();

        // R5: repeat correctable event is not recorded, overrun set
        fire(0, 34'h1_1111_1111, 64'h1, 8'h01, 14'h0001);
        rd_chk("R5 frozen", 8'h10, 32'hDEAD_BEEF);
        rd_chk("R5 overrun", 8'h00, 32'h3);
        check_all();

        // R3, R8: uncorrectable while correctable pending -> service CE
        fire(1, 34'h2_0000_0040, 64'hAAAA_5555_0000_FFFF, 8'h03, 14'h2A5A);
        rd_chk("R8 ce first", 8'h0C, 32'd1);
        rd_chk("R3 status", 8'h00, 32'h7);
        rd_chk("R4 src both", 8'h50, 32'h3FFF_2A5A);

        // R6, R8: partial ack then full ack
        wr(8'h04, 32'h1);
        rd_chk("R6 partial", 8'h00, 32'h6);
        rd_chk("R8 ce overrun", 8'h0C, 32'd1);
        wr(8'h04, 32'h2);
        rd_chk("R8 ue next", 8'h0C, 32'd2);
        check_all();

        // R9: writes to read-only and unmapped offsets
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF); wr(8'h30, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF); wr(8'h50, 32'h0); wr(8'h7C, 32'hFFFF_FFFF);
        rd_chk("R9 status", 8'h00, 32'h4);
        rd_chk("R9 ue addr", 8'h30, 32'h0000_0040);
        check_all();

        // R7: per-bit and global masking
        wr(8'h08, 32'h4);
        check("R7 bit mask", 32'(irq), 32'd0);
        wr(8'h08, 32'h8000_0000);
        check("R7 global", 32'(irq), 32'd0);
        wr(8'h08, 32'h7FFF_FFF0);
        rd_chk("R7 readback", 8'h08, 32'h0);
        check("R7 unmasked", 32'(irq), 32'd1);

        // R6: recapture after acknowledge
        wr(8'h04, 32'hF);
        fire(1, 34'h0_0000_1234, 64'h42, 8'h80, 14'h0007);
        rd_chk("R6 recapture", 8'h30, 32'h0000_1234);
        check_all();

        // random mix
        for (int i = 0; i < 150; i++) begin
            int k;
            k = int'($urandom_range(0, 5));
            case (k)
                0, 1: fire_rand(0);
                2:    fire_rand(1);
                3:    wr(8'h04, 32'($urandom_range(0, 15)));
                4:    wr(8'h08, $urandom);
                default: wr(8'(4 * $urandom_range(0, 31)) & 8'hF0 | 8'h00, $urandom);
            endcase
            if (k == 5) m_st = m_st; // R9: read-only write, model untouched
            check_all();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule